// File: doc/BRIEF.md
# Frame-aligned serial ADC deserializer

This block turns the double-data-rate serial output of an analog-to-digital converter into parallel sample words. Every bit-clock cycle it receives two bits that an input cell has already captured, one from the rising edge and one from the falling edge. It also receives the converter's frame clock, which it treats as a data signal and samples on the bit clock. A rising edge of the sampled frame clock marks the start of a word. The block then gathers bit pairs, most significant bit first, until the word is complete. It then presents the word on a parallel output together with a one-cycle valid strobe.

The converter powers up in a 14-bit serial mode with a bit-to-frame clock ratio of 7:1. It is later reprogrammed to 16 bits, which gives a ratio of 8:1. For that reason the block does not search for word boundaries while the configuration-done input is low. A mode input selects which ratio is expected. The block reports lock only after two frame edges in a row have arrived exactly one word period apart. It drops lock when an edge arrives early or late, or when an expected edge is missing. While lock is down, no word is released.

Top module: `fadc_deser`

## Requirements
- R1: While `rst_n` is low at a clock edge, `locked`, `sample_vld` and `sample_out` are all cleared to zero on that edge.
- R2: While `cfg_done` is low, `locked` stays 0 and `sample_vld` never pulses, whatever arrives on the frame and data inputs. Boundary search begins only once `cfg_done` is high.
- R3: `frame_smp` passes through two registers. A boundary is the cycle in which the newer sample is 1 and the older sample is 0. The bit pair presented in the same cycle as the first high `frame_smp` value is the first pair of a new word.
- R4: With `mode_14` = 0, a word is 8 consecutive pairs. Pair j (j = 0..7) carries bit 15-2j on `bit_rise` and bit 14-2j on `bit_fall`, and the full 16-bit word appears on `sample_out`.
- R5: With `mode_14` = 1, a word is 7 consecutive pairs. Pair j carries bit 13-2j on `bit_rise` and bit 12-2j on `bit_fall`. The word appears right-justified on `sample_out`, with bits 15:14 equal to 0.
- R6: `locked` rises only on a frame edge that comes exactly one word period (8 or 7 cycles) after the previous edge. A single edge after boundary search starts never sets it.
- R7: A frame edge at any position other than the expected word start clears `locked`, discards the partial word and restarts assembly from that edge.
- R8: When no frame edge arrives at the expected word start, `locked` clears and the block returns to searching for a boundary.
- R9: `sample_vld` is a single-cycle pulse issued together with each completed word, and only while `locked` is 1. Words completed while unlocked are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_rise | input | 1 | Bit captured on the rising bit-clock edge |
| bit_fall | input | 1 | Bit captured on the falling bit-clock edge |
| frame_smp | input | 1 | Frame clock, presented as a data level |
| cfg_done | input | 1 | High once the converter runs in the selected word length |
| mode_14 | input | 1 | 1 selects 14-bit words (7 pairs), 0 selects 16-bit words (8 pairs) |
| sample_out | output | 16 | Last completed word, right-justified |
| sample_vld | output | 1 | One-cycle strobe for a new word on `sample_out` |
| locked | output | 1 | Word boundary tracking is established |

## Verification
The assertions assume that `mode_14` stays fixed while `cfg_done` is high. They also assume that the frame and data inputs come from one capture stage, so that a frame edge and the first bit pair of a word arrive in the same cycle. The stimulus changes mode only under reset, with `cfg_done` low. It builds every frame from its word so that the frame level is high for the first half of the pairs and low for the rest. The only deliberate breaks in that pattern are one shortened frame, used to force a misplaced edge, and idle periods with no edges at all.

// File: rtl/fadc_pkg.sv
// Shared declarations for the frame-aligned deserializer.
// Assumes words carry an even number of bits (two per bit-clock cycle).
package fadc_pkg;

    // Boundary tracker states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // configuration not finished
        ST_HUNT  = 2'd1,   // waiting for the first frame edge
        ST_TRACK = 2'd2    // counting pairs against frame edges
    } sync_st_t;

    // Number of bit-clock cycles (bit pairs) per word of the given width
    function automatic int unsigned pairs_of(input int unsigned bits);
        return bits / 2;
    endfunction

endpackage

// File: rtl/fadc_edge_det.sv
// Frame boundary detector.
// Samples the frame clock through two registers and flags the cycle in
// which the newer sample is high and the older one low. The bit pair is
// delayed by one register so that it lines up with the newer frame sample.
// Assumes frame_smp and the bit pair come from the same capture edge.
module fadc_edge_det (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_smp,
    input  logic       bit_rise,
    input  logic       bit_fall,
    output logic [1:0] pair_q,
    output logic       frame_edge
);

    logic f_new;
    logic f_old;
    logic [1:0] pair_r;

    // Sample the frame level twice and delay the data pair once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_new  <= 1'b0;
            f_old  <= 1'b0;
            pair_r <= 2'b00;
        end else begin
            f_new  <= frame_smp;
            f_old  <= f_new;
            pair_r <= {bit_rise, bit_fall};
        end
    end

    assign frame_edge = f_new & ~f_old;
    assign pair_q     = pair_r;

endmodule

// File: rtl/fadc_frame_ctl.sv
// Boundary tracker.
// Counts bit pairs modulo the word length of the selected mode and checks
// each frame edge against the expected word start. It raises locked on
// two edges one word apart, and drops it on a misplaced or missing edge.
// Assumes mode_narrow is stable while cfg_done is high.
module fadc_frame_ctl #(
    parameter int unsigned WIDE_PAIRS   = 8,
    parameter int unsigned NARROW_PAIRS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_done,
    input  logic mode_narrow,
    input  logic frame_edge,
    output logic restart,
    output logic shift_en,
    output logic word_done,
    output logic locked
);
    import fadc_pkg::*;

    localparam int unsigned CNT_W = $clog2(WIDE_PAIRS);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WIDE_PAIRS - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_PAIRS - 1);

    sync_st_t         st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Index of the final pair of a word in the selected mode
    assign last = mode_narrow ? LAST_NARROW : LAST_WIDE;

    // Tracker state, pair counter and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_done) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            locked <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: st <= ST_HUNT;
                ST_HUNT: begin
                    if (frame_edge) begin
                        st  <= ST_TRACK;
                        cnt <= CNT_W'(1);
                    end
                end
                ST_TRACK: begin
                    if (frame_edge) begin
                        locked <= (cnt == '0);
                        cnt    <= CNT_W'(1);
                    end else if (cnt == '0) begin
                        locked <= 1'b0;
                        st     <= ST_HUNT;
                    end else if (cnt == last) begin
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Word assembly controls derived from state and count
    assign restart   = cfg_done && frame_edge && (st != ST_IDLE);
    assign shift_en  = cfg_done && (st == ST_TRACK);
    assign word_done = cfg_done && (st == ST_TRACK) && !frame_edge && (cnt == last);

endmodule

// File: rtl/fadc_word_asm.sv
// Word assembler.
// Shifts bit pairs in, rising-edge bit first, and captures the full word on
// word_done. In narrow mode the upper bits are cleared so that the word is
// right-justified. The valid strobe is gated by the lock flag.
// Assumes restart and shift_en come from the boundary tracker.
module fadc_word_asm #(
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pair,
    input  logic              restart,
    input  logic              shift_en,
    input  logic              word_done,
    input  logic              mode_narrow,
    input  logic              locked,
    output logic [WIDE_W-1:0] sample_out,
    output logic              sample_vld
);

    localparam int unsigned HOLD_W = WIDE_W - 2;
    localparam logic [WIDE_W-1:0] NARROW_MASK =
        {{(WIDE_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [HOLD_W-1:0] hold;
    logic [WIDE_W-1:0] word;

    // Full word formed by the stored pairs and the current pair
    assign word = {hold, pair};

    // Pair shift register with restart at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (restart) begin
            hold <= {{(HOLD_W - 2){1'b0}}, pair};
        end else if (shift_en) begin
            hold <= {hold[HOLD_W-3:0], pair};
        end
    end

    // Output register and gated strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= word_done && locked;
            if (word_done) begin
                sample_out <= mode_narrow ? (word & NARROW_MASK) : word;
            end
        end
    end

endmodule

// File: rtl/fadc_deser.sv
// Frame-aligned serial ADC deserializer, top level.
// Chains the boundary detector, the boundary tracker and the word
// assembler. Assumes bit pairs are already captured from both clock edges
// and that mode_14 changes only while cfg_done is low.
module fadc_deser #(
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              frame_smp,
    input  logic              cfg_done,
    input  logic              mode_14,
    output logic [WIDE_W-1:0] sample_out,
    output logic              sample_vld,
    output logic              locked
);
    import fadc_pkg::*;

    localparam int unsigned WIDE_PAIRS   = pairs_of(WIDE_W);
    localparam int unsigned NARROW_PAIRS = pairs_of(NARROW_W);

    logic [1:0] pair_w;
    logic       edge_w;
    logic       restart_w;
    logic       shift_w;
    logic       done_w;
    logic       locked_w;

    fadc_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_smp  (frame_smp),
        .bit_rise   (bit_rise),
        .bit_fall   (bit_fall),
        .pair_q     (pair_w),
        .frame_edge (edge_w)
    );

    fadc_frame_ctl #(
        .WIDE_PAIRS   (WIDE_PAIRS),
        .NARROW_PAIRS (NARROW_PAIRS)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_done    (cfg_done),
        .mode_narrow (mode_14),
        .frame_edge  (edge_w),
        .restart     (restart_w),
        .shift_en    (shift_w),
        .word_done   (done_w),
        .locked      (locked_w)
    );

    fadc_word_asm #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair        (pair_w),
        .restart     (restart_w),
        .shift_en    (shift_w),
        .word_done   (done_w),
        .mode_narrow (mode_14),
        .locked      (locked_w),
        .sample_out  (sample_out),
        .sample_vld  (sample_vld)
    );

    assign locked = locked_w;

endmodule

// File: rtl/fadc_deser_chk.sv
// Property checker for the deserializer, attached to the top by bind.
// Observes ports and the internal frame-edge flag.
module fadc_deser_chk #(
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_done,
    input logic              mode_14,
    input logic              frame_edge,
    input logic [WIDE_W-1:0] sample_out,
    input logic              sample_vld,
    input logic              locked
);

    // R2: configuration not done means no lock and no strobe next cycle
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> (!locked && !sample_vld));

    // R5: narrow words carry zero upper bits
    p_narrow_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && mode_14) |-> (sample_out[WIDE_W-1:NARROW_W] == '0));

    // R6: lock is gained only on a frame edge
    p_lock_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(frame_edge));

    // R9: strobe only while locked
    p_vld_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> locked);

    // R9: strobe lasts one cycle
    p_vld_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

endmodule

bind fadc_deser fadc_deser_chk #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_done   (cfg_done),
    .mode_14    (mode_14),
    .frame_edge (edge_w),
    .sample_out (sample_out),
    .sample_vld (sample_vld),
    .locked     (locked)
);

// File: tb/fadc_deser_bench.sv
// Self-checking bench: fixed-seed random words plus directed corners.
module fadc_deser_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_rise = 1'b0;
    logic        bit_fall = 1'b0;
    logic        frame_smp = 1'b0;
    logic        cfg_done = 1'b0;
    logic        mode_14 = 1'b0;
    logic [15:0] sample_out;
    logic        sample_vld;
    logic        locked;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    bit prev_vld = 1'b0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fadc_deser u_fadc_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_rise   (bit_rise),
        .bit_fall   (bit_fall),
        .frame_smp  (frame_smp),
        .cfg_done   (cfg_done),
        .mode_14    (mode_14),
        .sample_out (sample_out),
        .sample_vld (sample_vld),
        .locked     (locked)
    );

    // Expected output for a word in the given mode (R5 masks to 14 bits)
    function automatic logic [15:0] expect_word(input logic [15:0] w, input bit narrow);
        return narrow ? {2'b00, w[13:0]} : w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic drive_pair(input logic r, input logic f, input logic fr);
        @(negedge clk);
        bit_rise  = r;
        bit_fall  = f;
        frame_smp = fr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_pair(1'b0, 1'b0, 1'b0);
    endtask

    // Send the first n_send pairs of a word of np pairs, MSB first (R4, R5)
    task automatic send_word(input logic [15:0] w, input int np, input int n_send,
                             input bit expect_out);
        if (expect_out) exp_q.push_back(expect_word(w, np == 7));
        for (int j = 0; j < n_send; j++) begin
            drive_pair(w[2*np-1-2*j], w[2*np-2-2*j], j < (np + 1) / 2);
        end
    endtask

    task automatic do_reset(input logic narrow);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_done = 1'b0;
        mode_14 = narrow;
        bit_rise = 1'b0;
        bit_fall = 1'b0;
        frame_smp = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(locked == 1'b0, "R1 locked", {15'd0, locked}, 16'd0);
        check(sample_vld == 1'b0, "R1 sample_vld", {15'd0, sample_vld}, 16'd0);
        check(sample_out == 16'd0, "R1 sample_out", sample_out, 16'd0);
        rst_n = 1'b1;
    endtask

    // Scoreboard: every strobe must match the next expected word (R3, R9)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sample_vld) begin
                if (prev_vld) check(1'b0, "R9 strobe longer than one cycle", 16'd1, 16'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected strobe", sample_out, 16'd0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(sample_out == e, mode_14 ? "R3/R5 word" : "R3/R4 word", sample_out, e);
                end
            end
            prev_vld = sample_vld;
        end else begin
            prev_vld = 1'b0;
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0C0D);

        // R1: reset state, wide mode
        do_reset(1'b0);

        // R2: frames while configuration is not done produce nothing
        for (int k = 0; k < 4; k++) send_word(16'($urandom()), 8, 8, 1'b0);
        idle(2);
        check(locked == 1'b0, "R2 locked with cfg_done low", {15'd0, locked}, 16'd0);

        // Configuration done, then a first frame that must not lock (R6)
        idle(2);
        cfg_done = 1'b1;
        idle(3);
        send_word(16'h1234, 8, 8, 1'b0);
        check(locked == 1'b0, "R6 single edge", {15'd0, locked}, 16'd0);

        // R4: directed corner words then random words
        send_word(16'hFFFF, 8, 8, 1'b1);
        send_word(16'h0000, 8, 8, 1'b1);
        send_word(16'h8001, 8, 8, 1'b1);
        send_word(16'hAAAA, 8, 8, 1'b1);
        send_word(16'h5555, 8, 8, 1'b1);
        for (int k = 0; k < 20; k++) send_word(16'($urandom()), 8, 8, 1'b1);
        check(locked == 1'b1, "R6 locked after edges one word apart", {15'd0, locked}, 16'd1);

        // R7: shortened frame forces an early edge, partial word dropped
        send_word(16'($urandom()), 8, 5, 1'b0);
        send_word(16'($urandom()), 8, 8, 1'b0);
        check(locked == 1'b0, "R7 lock lost on misplaced edge", {15'd0, locked}, 16'd0);
        for (int k = 0; k < 6; k++) send_word(16'($urandom()), 8, 8, 1'b1);
        check(locked == 1'b1, "R7 relock", {15'd0, locked}, 16'd1);

        // R8: frames stop, lock must drop and all words must be out
        idle(12);
        check(locked == 1'b0, "R8 lock lost on missing edge", {15'd0, locked}, 16'd0);
        check(exp_q.size() == 0, "R4 all wide words delivered", 16'(exp_q.size()), 16'd0);

        // R5: narrow mode after reset
        do_reset(1'b1);
        idle(2);
        cfg_done = 1'b1;
        idle(3);
        send_word(16'h3FFF, 7, 7, 1'b0);
        send_word(16'h3FFF, 7, 7, 1'b1);
        send_word(16'h2001, 7, 7, 1'b1);
        send_word(16'h0000, 7, 7, 1'b1);
        send_word(16'h3FFF, 7, 7, 1'b1);
        for (int k = 0; k < 15; k++) send_word(16'($urandom()), 7, 7, 1'b1);
        check(locked == 1'b1, "R6 narrow lock", {15'd0, locked}, 16'd1);
        idle(12);
        check(locked == 1'b0, "R8 narrow lock lost", {15'd0, locked}, 16'd0);
        check(exp_q.size() == 0, "R5 all narrow words delivered", 16'(exp_q.size()), 16'd0);

        // R2: dropping configuration while locked stops output
        send_word(16'h0F0F, 7, 7, 1'b0);
        send_word(16'h0F0F, 7, 7, 1'b1);
        cfg_done = 1'b0;
        exp_q.delete();
        send_word(16'h0A0A, 7, 7, 1'b0);
        send_word(16'h0B0B, 7, 7, 1'b0);
        check(locked == 1'b0, "R2 locked after cfg_done drop", {15'd0, locked}, 16'd0);

        idle(4);
        finish_run();
    end

endmodule